// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Squash

This block keeps the program order of in-flight instructions for up to four hardware threads that share one pool of entries. A front end dispatches one tagged instruction per cycle into the queue of the thread that owns it. The tag carries a sequence number and a destination mapping. An execution side later marks entries complete by their entry index. Each cycle the block retires the oldest head that can leave across all threads. When a thread has to discard wrong-path work, it receives a squash request carrying a sequence number.

A squash does not rewind the tail. A walk starts at the youngest entry of the thread and moves toward older ones. It marks at most a fixed number of entries per cycle, and it stops at the first entry that is not younger than the requested number. Entries marked this way stay in place until they reach the head. There they are released without a commit, and the occupancy counts drop at that point. Per-thread status, done-squashing flags and occupancy flags let the surrounding pipeline throttle dispatch. The per-thread entry caps are inputs, so the allocation policy lives outside.

Top module: `mt_reorder_buf`

## Requirements
- R1: A dispatch to thread t is accepted, and `disp_ready[t]` is high, only when the whole buffer is not full, the occupancy of t is below its cap in `thr_limit`, and t is not squashing. A refused dispatch leaves all state unchanged. The entry index of an accepted dispatch is `{tid, slot}`, where the slot is the thread's tail slot shown on `disp_idx`.
- R2: `rob_full` is high when the summed occupancy equals ENTRIES, and `rob_empty` is high when it is zero. `thr_full[t]` is high when thread t alone holds ENTRIES entries, and `thr_empty[t]` is high when thread t holds none.
- R3: A squash request marks only entries of the named thread whose sequence number is greater than the requested one. It marks at most SQ_WIDTH entries per cycle, walking from the youngest entry toward older ones, and it leaves that thread's tail unchanged. With SQ_WIDTH=2, six entries and four younger ones, the thread stays squashing for exactly 3 cycles after the request cycle.
- R4: `thr_status` holds two bits per thread: 00 idle (empty), 01 running (holds entries), 10 squashing. The status enters 10 on the edge that takes the request. `thr_sq_done[t]` is low exactly while t is squashing. `all_sq_done` is high only when no thread is squashing.
- R5: Each cycle at most one head leaves: the one with the smallest sequence number among heads that are complete or squash-marked, in threads that are not squashing and have no squash request that cycle. It is reported on `commit_valid`, `commit_tid`, `commit_seq` and `commit_dest` only when it is not squash-marked.
- R6: A squash-marked entry that reaches the head is released without raising `commit_valid`, and the occupancy of its thread drops by one.
- R7: `can_commit` is high when some non-squashing thread has a complete, unmarked entry at its head.
- R8: A squash request for a thread that is already squashing restarts the walk from its tail, using the older (smaller) of the old and new sequence numbers.
- R9: A completion write sets the done bit of the entry at `cmpl_idx`. Retiring advances only the retiring thread's head slot on `thr_head`.
- R10: After reset every thread is idle and empty, the buffer is empty, every done-squashing flag is high and no commit is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tid | input | TID_W | Thread of the dispatched instruction |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_dest | input | DEST_W | Destination mapping tag |
| disp_ready | output | THREADS | Per-thread dispatch acceptance |
| disp_idx | output | IDX_W | Entry index that a dispatch this cycle receives |
| thr_limit | input | THREADS*CNT_W | Per-thread occupancy caps |
| cmpl_valid | input | 1 | Completion write enable |
| cmpl_idx | input | IDX_W | Entry index being completed |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Entries with a greater sequence number are discarded |
| commit_valid | output | 1 | An instruction commits this cycle |
| commit_tid | output | TID_W | Committing thread |
| commit_seq | output | SEQ_W | Committing sequence number |
| commit_dest | output | DEST_W | Committing destination tag |
| can_commit | output | 1 | Some thread has a ready head |
| thr_status | output | 2*THREADS | Per-thread status code |
| thr_sq_done | output | THREADS | Per-thread not-squashing flag |
| all_sq_done | output | 1 | No thread is squashing |
| thr_full | output | THREADS | Thread holds ENTRIES entries |
| thr_empty | output | THREADS | Thread holds no entries |
| rob_full | output | 1 | Total occupancy equals ENTRIES |
| rob_empty | output | 1 | Total occupancy is zero |
| thr_head | output | THREADS*SLOT_W | Per-thread head slot |
| thr_tail | output | THREADS*SLOT_W | Per-thread tail slot |

## Verification
A corrupted squash bound or walk pointer shows up within a few cycles. Either a discarded sequence number reaches the commit port, or a surviving one never does and the thread's occupancy flag stays low for good. A wrong oldest-head choice shows at once as a commit out of the scoreboard's expected order. An occupancy counter that has drifted shows as a wrong full, empty or ready flag on the next dispatch attempt. The squash walk length can be observed at the ports in cycles, so an off-by-one in the width handling changes the measured duration at once.

// File: rtl/mt_reorder_buf.sv
module mt_reorder_buf #(
  parameter int THREADS  = 4,
  parameter int ENTRIES  = 16,
  parameter int SQ_WIDTH = 2,
  parameter int SEQ_W    = 16,
  parameter int DEST_W   = 8,
  localparam int TID_W  = $clog2(THREADS),
  localparam int SLOT_W = $clog2(ENTRIES),
  localparam int IDX_W  = TID_W + SLOT_W,
  localparam int CNT_W  = $clog2(ENTRIES + 1),
  localparam int SLOTS  = THREADS * ENTRIES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      disp_valid,
  input  logic [TID_W-1:0]          disp_tid,
  input  logic [SEQ_W-1:0]          disp_seq,
  input  logic [DEST_W-1:0]         disp_dest,
  output logic [THREADS-1:0]        disp_ready,
  output logic [IDX_W-1:0]          disp_idx,
  input  logic [THREADS*CNT_W-1:0]  thr_limit,
  input  logic                      cmpl_valid,
  input  logic [IDX_W-1:0]          cmpl_idx,
  input  logic                      sq_valid,
  input  logic [TID_W-1:0]          sq_tid,
  input  logic [SEQ_W-1:0]          sq_seq,
  output logic                      commit_valid,
  output logic [TID_W-1:0]          commit_tid,
  output logic [SEQ_W-1:0]          commit_seq,
  output logic [DEST_W-1:0]         commit_dest,
  output logic                      can_commit,
  output logic [2*THREADS-1:0]      thr_status,
  output logic [THREADS-1:0]        thr_sq_done,
  output logic                      all_sq_done,
  output logic [THREADS-1:0]        thr_full,
  output logic [THREADS-1:0]        thr_empty,
  output logic                      rob_full,
  output logic                      rob_empty,
  output logic [THREADS*SLOT_W-1:0] thr_head,
  output logic [THREADS*SLOT_W-1:0] thr_tail
);

  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_RUN  = 2'b01;
  localparam logic [1:0] ST_SQ   = 2'b10;

  logic [SLOT_W-1:0] head_q [THREADS];
  logic [SLOT_W-1:0] tail_q [THREADS];
  logic [SLOT_W-1:0] wptr_q [THREADS];
  logic [CNT_W-1:0]  occ_q  [THREADS];
  logic [CNT_W-1:0]  walked_q [THREADS];
  logic [CNT_W-1:0]  occ_nx [THREADS];
  logic [1:0]        st_q   [THREADS];
  logic [SEQ_W-1:0]  sqseq_q [THREADS];

  logic [SEQ_W-1:0]  seq_q  [SLOTS];
  logic [DEST_W-1:0] dest_q [SLOTS];
  logic [SLOTS-1:0]  done_q, sqd_q;

  logic [CNT_W-1:0]    total;
  logic                acc;
  logic [THREADS-1:0]  d_hit, r_hit, fin;
  logic [SQ_WIDTH-1:0] mark [THREADS];
  logic                rel_valid;
  logic [TID_W-1:0]    sel_t;
  logic [IDX_W-1:0]    sel_e;
  logic [SEQ_W-1:0]    sel_seq;

  always_comb begin
    total = '0;
    for (int t = 0; t < THREADS; t++) total = total + occ_q[t];
  end

  assign rob_full    = (total == CNT_W'(ENTRIES));
  assign rob_empty   = (total == '0);
  assign all_sq_done = &thr_sq_done;
  assign acc         = disp_valid && disp_ready[disp_tid];
  assign disp_idx    = {disp_tid, tail_q[disp_tid]};

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    assign disp_ready[t] = !rob_full && (occ_q[t] < thr_limit[t*CNT_W +: CNT_W]) && (st_q[t] != ST_SQ);
    assign thr_status[2*t +: 2] = st_q[t];
    assign thr_sq_done[t] = (st_q[t] != ST_SQ);
    assign thr_full[t]    = (occ_q[t] == CNT_W'(ENTRIES));
    assign thr_empty[t]   = (occ_q[t] == '0);
    assign thr_head[t*SLOT_W +: SLOT_W] = head_q[t];
    assign thr_tail[t*SLOT_W +: SLOT_W] = tail_q[t];
    assign d_hit[t]  = acc && (disp_tid == TID_W'(t));
    assign r_hit[t]  = rel_valid && (sel_t == TID_W'(t));
    assign occ_nx[t] = occ_q[t] + CNT_W'(d_hit[t]) - CNT_W'(r_hit[t]);
  end

  always_comb begin
    rel_valid  = 1'b0;
    can_commit = 1'b0;
    sel_t      = '0;
    sel_e      = '0;
    sel_seq    = '0;
    for (int t = 0; t < THREADS; t++) begin
      logic [IDX_W-1:0] e;
      logic live;
      e    = {TID_W'(t), head_q[t]};
      live = (occ_q[t] != '0) && (st_q[t] != ST_SQ) && !(sq_valid && sq_tid == TID_W'(t));
      if (live && done_q[e] && !sqd_q[e]) can_commit = 1'b1;
      if (live && (done_q[e] || sqd_q[e]) && (!rel_valid || seq_q[e] < sel_seq)) begin
        rel_valid = 1'b1;
        sel_t     = TID_W'(t);
        sel_e     = e;
        sel_seq   = seq_q[e];
      end
    end
  end

  assign commit_valid = rel_valid && !sqd_q[sel_e];
  assign commit_tid   = sel_t;
  assign commit_seq   = sel_seq;
  assign commit_dest  = dest_q[sel_e];

  always_comb begin
    for (int t = 0; t < THREADS; t++) begin
      logic stop;
      mark[t] = '0;
      stop    = 1'b0;
      for (int k = 0; k < SQ_WIDTH; k++) begin
        if (!stop) begin
          if ((st_q[t] == ST_SQ) && (int'(walked_q[t]) + k < int'(occ_q[t])) &&
              (seq_q[{TID_W'(t), wptr_q[t] - SLOT_W'(k)}] > sqseq_q[t]))
            mark[t][k] = 1'b1;
          else
            stop = 1'b1;
        end
      end
      fin[t] = stop || (int'(walked_q[t]) + SQ_WIDTH >= int'(occ_q[t]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) begin
        head_q[t]   <= '0;
        tail_q[t]   <= '0;
        wptr_q[t]   <= '0;
        occ_q[t]    <= '0;
        walked_q[t] <= '0;
        st_q[t]     <= ST_IDLE;
        sqseq_q[t]  <= '0;
      end
      done_q <= '0;
      sqd_q  <= '0;
    end else begin
      for (int t = 0; t < THREADS; t++) begin
        if (d_hit[t]) tail_q[t] <= tail_q[t] + SLOT_W'(1);
        if (r_hit[t]) head_q[t] <= head_q[t] + SLOT_W'(1);
        occ_q[t] <= occ_nx[t];
        if (sq_valid && sq_tid == TID_W'(t)) begin
          st_q[t]     <= ST_SQ;
          sqseq_q[t]  <= (st_q[t] == ST_SQ && sqseq_q[t] < sq_seq) ? sqseq_q[t] : sq_seq;
          walked_q[t] <= '0;
          wptr_q[t]   <= d_hit[t] ? tail_q[t] : tail_q[t] - SLOT_W'(1);
        end else if (st_q[t] == ST_SQ) begin
          if (fin[t]) begin
            st_q[t] <= (occ_q[t] != '0) ? ST_RUN : ST_IDLE;
          end else begin
            walked_q[t] <= walked_q[t] + CNT_W'(SQ_WIDTH);
            wptr_q[t]   <= wptr_q[t] - SLOT_W'(SQ_WIDTH);
          end
        end else begin
          st_q[t] <= (occ_nx[t] != '0) ? ST_RUN : ST_IDLE;
        end
        for (int k = 0; k < SQ_WIDTH; k++)
          if (mark[t][k]) sqd_q[{TID_W'(t), wptr_q[t] - SLOT_W'(k)}] <= 1'b1;
      end
      if (cmpl_valid) done_q[cmpl_idx] <= 1'b1;
      if (acc) begin
        done_q[disp_idx] <= 1'b0;
        sqd_q[disp_idx]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      seq_q[disp_idx]  <= disp_seq;
      dest_q[disp_idx] <= disp_dest;
    end
  end

endmodule

// File: rtl/mt_reorder_buf_chk.sv
module mt_reorder_buf_chk #(
  parameter int THREADS = 4,
  parameter int TID_W   = 2,
  parameter int SLOT_W  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sq_valid,
  input logic [TID_W-1:0]          sq_tid,
  input logic [THREADS-1:0]        thr_sq_done,
  input logic [THREADS-1:0]        thr_empty,
  input logic [THREADS*SLOT_W-1:0] thr_tail,
  input logic                      commit_valid,
  input logic [TID_W-1:0]          commit_tid,
  input logic                      can_commit,
  input logic                      rob_empty
);

  // R5
  commit_from_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> thr_sq_done[commit_tid]);

  // R7
  ready_needs_entries_chk: assert property (@(posedge clk) disable iff (!rst_n)
    can_commit |-> !rob_empty);

  // R2
  empty_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rob_empty |-> (&thr_empty));

  for (genvar t = 0; t < THREADS; t++) begin : g_chk
    // R4
    sq_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_valid && sq_tid == TID_W'(t)) |=> !thr_sq_done[t]);

    // R3
    sq_tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !thr_sq_done[t] |=> thr_tail[t*SLOT_W +: SLOT_W] == $past(thr_tail[t*SLOT_W +: SLOT_W]));

    // R6
    empty_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_empty[t] |-> !(commit_valid && commit_tid == TID_W'(t)));
  end

endmodule

bind mt_reorder_buf mt_reorder_buf_chk #(.THREADS(THREADS), .TID_W(TID_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_tid(sq_tid),
  .thr_sq_done(thr_sq_done), .thr_empty(thr_empty), .thr_tail(thr_tail),
  .commit_valid(commit_valid), .commit_tid(commit_tid),
  .can_commit(can_commit), .rob_empty(rob_empty)
);

// File: tb/mt_reorder_buf_tb.sv
module mt_reorder_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int THREADS = 4, ENTRIES = 16, SQ_WIDTH = 2, SEQ_W = 16, DEST_W = 8;
  localparam int TID_W = 2, SLOT_W = 4, IDX_W = 6, CNT_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0, cmpl_valid = 1'b0, sq_valid = 1'b0;
  logic [TID_W-1:0] disp_tid = '0, sq_tid = '0;
  logic [SEQ_W-1:0] disp_seq = '0, sq_seq = '0;
  logic [DEST_W-1:0] disp_dest = '0;
  logic [IDX_W-1:0] cmpl_idx = '0;
  logic [THREADS*CNT_W-1:0] thr_limit = {THREADS{5'd16}};
  logic [THREADS-1:0] disp_ready, thr_sq_done, thr_full, thr_empty;
  logic [IDX_W-1:0] disp_idx;
  logic commit_valid, can_commit, all_sq_done, rob_full, rob_empty;
  logic [TID_W-1:0] commit_tid;
  logic [SEQ_W-1:0] commit_seq;
  logic [DEST_W-1:0] commit_dest;
  logic [2*THREADS-1:0] thr_status;
  logic [THREADS*SLOT_W-1:0] thr_head, thr_tail;

  mt_reorder_buf #(.THREADS(THREADS), .ENTRIES(ENTRIES), .SQ_WIDTH(SQ_WIDTH),
                   .SEQ_W(SEQ_W), .DEST_W(DEST_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tid(disp_tid),
    .disp_seq(disp_seq), .disp_dest(disp_dest), .disp_ready(disp_ready),
    .disp_idx(disp_idx), .thr_limit(thr_limit), .cmpl_valid(cmpl_valid),
    .cmpl_idx(cmpl_idx), .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .commit_valid(commit_valid), .commit_tid(commit_tid), .commit_seq(commit_seq),
    .commit_dest(commit_dest), .can_commit(can_commit), .thr_status(thr_status),
    .thr_sq_done(thr_sq_done), .all_sq_done(all_sq_done), .thr_full(thr_full),
    .thr_empty(thr_empty), .rob_full(rob_full), .rob_empty(rob_empty),
    .thr_head(thr_head), .thr_tail(thr_tail));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;
  bit finished = 1'b0;
  logic [TID_W+SEQ_W+DEST_W-1:0] exp_q[$];
  logic [IDX_W-1:0] ix [32];

  function automatic logic [DEST_W-1:0] dmap(input int s);
    return DEST_W'(s) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_commit(input int t, input int s);
    exp_q.push_back({TID_W'(t), SEQ_W'(s), dmap(s)});
  endtask

  task automatic dispatch(input int t, input int s, output logic [IDX_W-1:0] idx);
    disp_valid = 1'b1; disp_tid = TID_W'(t); disp_seq = SEQ_W'(s); disp_dest = dmap(s);
    #1;
    idx = disp_idx;
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic complete(input logic [IDX_W-1:0] idx);
    cmpl_valid = 1'b1; cmpl_idx = idx;
    tick();
    cmpl_valid = 1'b0;
  endtask

  task automatic squash(input int t, input int s);
    sq_valid = 1'b1; sq_tid = TID_W'(t); sq_seq = SEQ_W'(s);
    tick();
    sq_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (24) tick();
    chk(req, "pending expected commits", exp_q.size(), 0);
  endtask

  task automatic walk_len(input int t, input string req, input int exp_n);
    int n = 0;
    while (!thr_sq_done[t] && n < 50) begin
      tick();
      n++;
    end
    chk(req, "squash walk cycles", n, exp_n);
  endtask

  // Scoreboard monitor: every architectural commit must match the queue head (R5)
  always @(negedge clk) begin
    if (rst_n && commit_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected commit actual=t%0d/seq%0d expected=none", commit_tid, commit_seq);
      end else begin
        logic [TID_W+SEQ_W+DEST_W-1:0] e;
        e = exp_q.pop_front();
        if ({commit_tid, commit_seq, commit_dest} !== e) begin
          fails++;
          $display("FAIL R5 commit actual=t%0d/seq%0d/d%0h expected=t%0d/seq%0d/d%0h",
                   commit_tid, commit_seq, commit_dest,
                   e[TID_W+SEQ_W+DEST_W-1 -: TID_W], e[SEQ_W+DEST_W-1 -: SEQ_W], e[DEST_W-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    chk("R10", "rob_empty", rob_empty, 1);
    chk("R10", "rob_full", rob_full, 0);
    chk("R10", "all_sq_done", all_sq_done, 1);
    chk("R10", "thr_status", thr_status, 0);
    chk("R10", "can_commit", can_commit, 0);
    chk("R10", "commit_valid", commit_valid, 0);
    chk("R1", "disp_ready after reset", disp_ready, 4'hF);

    // R5 R7 R9: oldest ready head across threads
    dispatch(0, 3, ix[0]);
    dispatch(0, 10, ix[1]);
    dispatch(1, 1, ix[2]);
    dispatch(1, 5, ix[3]);
    chk("R1", "disp_idx t0 second", ix[1], 6'h01);
    chk("R1", "disp_idx t1 first", ix[2], 6'h10);
    chk("R4", "status running t0 t1", thr_status, 8'b0000_0101);
    complete(ix[1]);
    complete(ix[3]);
    chk("R7", "can_commit with unready heads", can_commit, 0);
    expect_commit(0, 3);
    expect_commit(1, 1);
    expect_commit(1, 5);
    expect_commit(0, 10);
    complete(ix[0]);
    chk("R7", "can_commit with ready head", can_commit, 1);
    chk("R9", "t1 head before its retire", thr_head[1*SLOT_W +: SLOT_W], 0);
    complete(ix[2]);
    drain("R5");
    chk("R9", "t0 head after retire", thr_head[0 +: SLOT_W], 2);
    chk("R9", "t1 head after retire", thr_head[1*SLOT_W +: SLOT_W], 2);
    chk("R9", "t2 head untouched", thr_head[2*SLOT_W +: SLOT_W], 0);
    chk("R2", "rob_empty after drain", rob_empty, 1);

    // R1: per-thread cap
    thr_limit[2*CNT_W +: CNT_W] = 5'd2;
    #1;
    dispatch(2, 20, ix[0]);
    dispatch(2, 21, ix[1]);
    chk("R1", "t2 ready at cap", disp_ready[2], 0);
    chk("R1", "t0 ready below cap", disp_ready[0], 1);
    dispatch(2, 22, ix[2]);
    chk("R1", "refused dispatch keeps t2 tail", thr_tail[2*SLOT_W +: SLOT_W], 2);
    expect_commit(2, 20);
    expect_commit(2, 21);
    complete(ix[0]);
    complete(ix[1]);
    drain("R1");
    thr_limit[2*CNT_W +: CNT_W] = 5'd16;

    // R2: whole buffer full from one thread
    for (int i = 0; i < 16; i++) dispatch(3, 300 + i, ix[i]);
    chk("R2", "rob_full", rob_full, 1);
    chk("R2", "thr_full t3", thr_full[3], 1);
    chk("R1", "no ready when full", disp_ready, 0);
    dispatch(0, 400, ix[16]);
    chk("R1", "refused dispatch keeps t0 empty", thr_empty[0], 1);
    for (int i = 0; i < 16; i++) begin
      expect_commit(3, 300 + i);
      complete(ix[i]);
    end
    drain("R2");
    chk("R2", "thr_empty all", thr_empty, 4'hF);

    // R3 R4 R6: squash walk on t1, other thread untouched
    for (int i = 0; i < 6; i++) dispatch(1, 100 + i, ix[i]);
    dispatch(0, 103, ix[8]);
    squash(1, 101);
    chk("R4", "t1 status squashing", thr_status[2 +: 2], 2'b10);
    chk("R4", "all_sq_done low", all_sq_done, 0);
    chk("R1", "no dispatch while squashing", disp_ready[1], 0);
    walk_len(1, "R3", 3);
    chk("R3", "t1 tail kept after walk", thr_tail[1*SLOT_W +: SLOT_W], 8);
    chk("R4", "all_sq_done high", all_sq_done, 1);
    expect_commit(0, 103);
    complete(ix[8]);
    expect_commit(1, 100);
    expect_commit(1, 101);
    complete(ix[0]);
    complete(ix[1]);
    drain("R3");
    chk("R6", "squashed entries released t1", thr_empty[1], 1);
    chk("R6", "rob_empty after release", rob_empty, 1);

    // R8: restart keeps the older sequence number
    for (int i = 0; i < 8; i++) dispatch(2, 200 + i, ix[i]);
    squash(2, 202);
    squash(2, 205);
    walk_len(2, "R8", 3);
    expect_commit(2, 200);
    expect_commit(2, 201);
    expect_commit(2, 202);
    for (int i = 0; i < 8; i++) complete(ix[i]);
    drain("R8");
    chk("R8", "t2 empty after release", thr_empty[2], 1);
    chk("R10", "idle after all", thr_status, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule